// File: doc/BRIEF.md
# Programmable Pulse Burst Generator

This block drives a single wave output with a burst of pulses whose timing is set by two programmable compare values. A start request loads both values and launches the burst. A phase counter then advances by one every clock. The wave goes high in the cycle after the counter equals the rise value. It stays high, with the counter still running, until the cycle after the counter equals the fall value. At that point the wave drops and the counter restarts from zero.

Every rising edge of the wave is tallied. When the fall that ends pulse number `PULSES` (default 50) arrives, the machine returns to idle. It raises a one-cycle completion strobe and waits for the next start. A start whose rise value is not below its fall value is refused.

Top module: `burst_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no start, wave, busy and done are all 0.
- R2: A start sampled in idle with rise_at < fall_at makes busy 1 after that edge. Both compare values are captured at that edge, and later changes on rise_at and fall_at have no effect on the burst.
- R3: The phase counter is 0 in the first busy cycle and advances by one per clock. The wave goes high after the edge at which the counter equals the captured rise value, so the first pulse rises rise_at+1 cycles after the start edge.
- R4: The wave holds high through every cycle without a compare match and goes low after the edge at which the counter equals the captured fall value. The counter then restarts at 0, giving a pulse high for fall_at-rise_at cycles and a period of fall_at+1 cycles.
- R5: Exactly PULSES (50) pulses are produced. busy falls after the edge that ends the last pulse, which is PULSES*(fall_at+1) cycles after the start edge.
- R6: done is 1 for exactly one cycle, in the first idle cycle after a completed burst, and is 0 at all other times.
- R7: A start with rise_at >= fall_at is refused: busy and wave stay 0.
- R8: A start asserted while busy is ignored, and the burst in progress keeps its timing.
- R9: The wave is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to begin a burst, sampled in idle |
| rise_at | input | CNT_W | Counter value at which the wave rises |
| fall_at | input | CNT_W | Counter value at which the wave falls and the counter restarts |
| wave | output | 1 | Pulse output, registered |
| busy | output | 1 | High while a burst is running |
| done | output | 1 | One-cycle strobe after the last pulse |

## Verification
Every result is given as a cycle offset from the edge that samples start. busy is due one edge later. Pulse n rises after edge 1+rise_at+(n-1)(fall_at+1) and falls after edge n(fall_at+1). busy and done change after edge PULSES*(fall_at+1). The bench samples on the falling clock edge after each rising edge and computes this expected waveform per offset. It compares wave, busy and done against that waveform on every cycle of every burst, so a shift of a single cycle is reported. Refused and ignored starts are checked by watching busy and wave in the cycles that follow them.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } burst_state_t;
endpackage

// File: rtl/burst_cnt.sv
module burst_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         en;

  assign en    = clr | inc;
  assign q_nxt = clr ? '0 : q + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_nxt;
  end
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic thr_ok,
  input  logic hit_rise,
  input  logic hit_fall,
  input  logic last,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic loop_clr,
  output logic loop_inc,
  output logic cap_en,
  output logic active,
  output logic wave_q,
  output logic done_q
);
  burst_state_t st, st_nxt;
  logic wave_nxt, done_nxt;

  always_comb begin
    st_nxt   = st;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    loop_clr = 1'b0;
    loop_inc = 1'b0;
    cap_en   = 1'b0;
    wave_nxt = wave_q;
    done_nxt = 1'b0;
    unique case (st)
      ST_IDLE: begin
        cnt_clr  = 1'b1;
        loop_clr = 1'b1;
        wave_nxt = 1'b0;
        if (start && thr_ok) begin
          cap_en = 1'b1;
          st_nxt = ST_LOW;
        end
      end
      ST_LOW: begin
        cnt_inc = 1'b1;
        if (hit_rise) begin
          wave_nxt = 1'b1;
          loop_inc = 1'b1;
          st_nxt   = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (hit_fall) begin
          wave_nxt = 1'b0;
          cnt_clr  = 1'b1;
          if (last) begin
            loop_clr = 1'b1;
            done_nxt = 1'b1;
            st_nxt   = ST_IDLE;
          end else begin
            st_nxt = ST_LOW;
          end
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      wave_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st     <= st_nxt;
      wave_q <= wave_nxt;
      done_q <= done_nxt;
    end
  end

  assign active = (st != ST_IDLE);
endmodule

// File: rtl/burst_gen.sv
module burst_gen #(
  parameter int CNT_W  = 8,
  parameter int PULSES = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] rise_at,
  input  logic [CNT_W-1:0] fall_at,
  output logic             wave,
  output logic             busy,
  output logic             done
);
  localparam int LOOP_W = $clog2(PULSES + 1);

  logic [1:0]        rst_sync;
  logic              rst_n_i;
  logic [CNT_W-1:0]  rise_q, fall_q, phase;
  logic [LOOP_W-1:0] loops;
  logic cnt_clr, cnt_inc, loop_clr, loop_inc, cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (cap_en) begin
      rise_q <= rise_at;
      fall_q <= fall_at;
    end
  end

  burst_cnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n_i), .clr(cnt_clr), .inc(cnt_inc), .q(phase)
  );

  burst_cnt #(.W(LOOP_W)) u_loops (
    .clk(clk), .rst_n(rst_n_i), .clr(loop_clr), .inc(loop_inc), .q(loops)
  );

  burst_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (start),
    .thr_ok   (rise_at < fall_at),
    .hit_rise (phase == rise_q),
    .hit_fall (phase == fall_q),
    .last     (loops == LOOP_W'(PULSES)),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .loop_clr (loop_clr),
    .loop_inc (loop_inc),
    .cap_en   (cap_en),
    .active   (busy),
    .wave_q   (wave),
    .done_q   (done)
  );
endmodule

// File: rtl/burst_gen_chk.sv
module burst_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] rise_at,
  input logic [CNT_W-1:0] fall_at,
  input logic             wave,
  input logic             busy,
  input logic             done
);
  // R9: no wave outside a burst
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wave);

  // R6: completion strobe lasts one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: strobe only in the first idle cycle after a burst
  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wave && $past(busy)));

  // R7: refused start leaves the block idle
  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (rise_at >= fall_at)) |=> !busy);

  // R2: a burst begins only from an accepted start
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && (rise_at < fall_at)));

  // R3: rising edges only inside a burst
  assert_rise_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave) |-> busy);
endmodule

bind burst_gen burst_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rise_at(rise_at),
  .fall_at(fall_at), .wave(wave), .busy(busy), .done(done)
);

// File: tb/tb_burst_gen.sv
module tb_burst_gen;
  localparam int W = 8;
  localparam int NP = 50;
  localparam int NV = 6;
  // columns: rise value, fall value, cycle offset of a start poke (0 = none)
  localparam int VEC [NV][3] = '{
    '{0,   1,   0},
    '{2,   5,   0},
    '{3,   4,   7},
    '{10,  20,  30},
    '{0,   255, 0},
    '{254, 255, 900}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] rise_at = '0, fall_at = '0;
  logic wave, busy, done;
  int checks = 0;
  int bad = 0;

  always #5 clk = ~clk;

  burst_gen #(.CNT_W(W), .PULSES(NP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rise_at(rise_at),
    .fall_at(fall_at), .wave(wave), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int r, input int f, input int poke);
    int last_t, mw, mb, md, rises;
    logic prev;
    bit ew, eb, ed;
    mw = 0; mb = 0; md = 0; rises = 0; prev = 1'b0;
    last_t = NP * (f + 1);
    @(negedge clk);
    start = 1'b1; rise_at = W'(r); fall_at = W'(f);
    @(negedge clk);
    start = 1'b0; rise_at = W'(f); fall_at = W'(r);  // R2: captured values must hold
    for (int t = 0; t <= last_t + 3; t++) begin
      if (t > 0) @(negedge clk);
      start = 1'b0;
      if (t <= 0 || t >= last_t) ew = 1'b0;
      else ew = (((t - 1) % (f + 1)) >= r) && (((t - 1) % (f + 1)) < f);
      eb = (t < last_t);
      ed = (t == last_t);
      if (wave !== ew) mw++;
      if (busy !== eb) mb++;
      if (done !== ed) md++;
      if (wave && !prev) rises++;
      prev = wave;
      if (poke != 0 && t == poke) begin
        start = 1'b1; rise_at = 8'd0; fall_at = 8'd1;  // R8 poke while busy
      end
    end
    chk(mw == 0, "R3/R4 wave timing mismatched cycles", mw, 0);
    chk(rises == NP, "R5 pulse count", rises, NP);
    chk(mb == 0, "R2/R5 busy window mismatched cycles", mb, 0);
    chk(md == 0, "R6 done strobe mismatched cycles", md, 0);
    if (poke != 0) chk(mw == 0 && mb == 0, "R8 start while busy altered burst", mw + mb, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wave && !busy && !done, "R1 outputs during reset", {wave, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wave && !busy && !done, "R1 outputs after reset release", {wave, busy, done}, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i][0], VEC[i][1], VEC[i][2]);

    // R7: equal compare values refused
    @(negedge clk); start = 1'b1; rise_at = 8'd5; fall_at = 8'd5;
    @(negedge clk); start = 1'b0;
    chk(!busy, "R7 equal values busy", busy, 0);
    repeat (8) @(negedge clk);
    chk(!busy && !wave, "R7 equal values stay idle", {busy, wave}, 0);

    // R7: rise above fall refused
    @(negedge clk); start = 1'b1; rise_at = 8'd9; fall_at = 8'd3;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    chk(!busy && !wave && !done, "R7 inverted values stay idle", {busy, wave, done}, 0);

    // R9: block still usable after refusals, idle output low
    run_vec(1, 3, 0);
    chk(!wave, "R9 wave low in idle", wave, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule